// File: doc/BRIEF.md
# Time-Slot Serial Audio Frame Receiver

This block is the receive end of a framed serial audio link that runs at a fixed frame rate. Each frame is 256 bit-clock periods long. A frame opens with a 16-bit tag slot and continues with twelve 20-bit data slots. The sender changes the frame-start strobe and the serial data on the rising edge of the bit clock. The receiver samples both on the falling edge, so every register in the block is clocked on the falling edge.

The block locks to the frame grid when it sees the strobe go from low to high. It reads the frame-valid flag and the per-slot tags from the tag slot, and deserializes every data slot. A slot that its frame allows is presented as a parallel word with its slot number, a one-cycle strobe and a kind code. The kind code tells the slot apart: command address, command data, left PCM or right PCM.

When several receivers share one link, each receiver is given an index. That index decides which pair of PCM slots it takes. The receiver also flags a strobe edge that arrives off the expected frame boundary, and it realigns its counters to that edge.

Top module: `tslot_frame_rx`

## Requirements
- R1: `sync_in` and `sdata_in` are sampled on falling edges of `bit_clk`. The falling edge on which `sync_in` is first seen high after being low is a frame start. The next sample after that edge is frame bit 0.
- R2: After reset and until the first frame start, `locked` stays 0 and `out_valid` never rises. From the first frame start on, `locked` is 1.
- R3: Frame layout, with every field sent MSB first.
  - Frame bit 0 is the frame-valid flag.
  - Frame bits 1 to 12 are the tags for slots 1 to 12, in slot order.
  - Frame bits 13 to 15 are unused, which completes the 16-bit tag slot.
  - Slot k (1 to 12) occupies frame bits 16+20(k-1) to 16+20k-1.
- R4: For each accepted slot, `out_valid` is high for exactly one bit-clock period. The pulse starts at the falling edge that samples the slot's last bit. `out_slot` then carries the slot number and `out_word` carries the 20-bit word.
- R5: A slot whose tag is 0 gives no output.
- R6: When the frame-valid flag is 0, no slot of that frame gives an output, whatever the tags say.
- R7: Slot 1 is reported with `out_kind` = 1 (command address) and slot 2 with `out_kind` = 2 (command data).
- R8: With `multi_en` = 0, slots 3 to 12 are all accepted when tagged. Slot 3 has `out_kind` = 3 (left PCM), slot 4 has `out_kind` = 4 (right PCM), and slots 5 to 12 have `out_kind` = 0.
- R9: With `multi_en` = 1, of the PCM slots 3 to 8 only one pair is accepted, chosen by `rx_index`:
  - `rx_index` 0 takes slots 3 and 4.
  - `rx_index` 1 takes slots 5 and 6.
  - `rx_index` 2 takes slots 7 and 8.
  - `rx_index` 3 takes none of them.
  
  The first slot of the pair is reported as kind 3 and the second as kind 4. Slots 1, 2 and 9 to 12 behave as in R7 and R8.
- R10: A strobe rising edge seen while locked at any sample other than the last bit of slot 12 gives a one-cycle `lock_err` pulse. The slot being received at that moment is dropped, and counting restarts so that the next sample is frame bit 0. A rising edge seen exactly on that last bit gives no `lock_err`, and slot 12 is still delivered.
- R11: Without a new strobe edge, the counters wrap after 256 bits and the next 256 bits are decoded as a frame.
- R12: Reset is asynchronous and active low. While `rst_n` is 0, `out_valid`, `locked` and `lock_err` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Serial bit clock; all sampling on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | Frame-start strobe from the sender |
| sdata_in | input | 1 | Serial frame data, MSB first per field |
| multi_en | input | 1 | Selects shared-link (multi-receiver) slot acceptance |
| rx_index | input | 2 | Receiver index used when `multi_en` is 1 |
| out_valid | output | 1 | One-cycle strobe for an accepted slot |
| out_slot | output | 4 | Number (1-12) of the delivered slot |
| out_word | output | 20 | Deserialized slot word |
| out_kind | output | 3 | 0 other, 1 command address, 2 command data, 3 left PCM, 4 right PCM |
| locked | output | 1 | Frame grid acquired since reset |
| lock_err | output | 1 | Pulse: strobe edge off the expected boundary |

## Verification
The main decode is driven with several frame patterns:
- A frame with every tag set proves the bit alignment, the word assembly and the kind codes.
- A sparse tag pattern separates per-slot gating from frame-level gating.
- A frame whose valid flag is cleared but whose tags are all set proves that the frame flag alone suppresses output.

The same fully tagged frame is then sent with each of the four receiver indices in shared mode, so that each index's slot pair is told apart from its neighbours'. A frame sent with no strobe proves the counter wrap. A truncated frame followed by an early strobe separates a misaligned edge, which must flag an error and drop the partial slot, from the aligned edges that every other frame uses.

// File: rtl/tsrx_pkg.sv
`timescale 1ns/1ps
package tsrx_pkg;
  // receivers that can share one link, and the first PCM slot of the shared range
  localparam int N_RX      = 3;
  localparam int PCM_FIRST = 3;
  localparam int RXI_W     = $clog2(N_RX + 1);

  typedef enum logic [2:0] {
    KIND_OTHER    = 3'd0,
    KIND_CMD_ADDR = 3'd1,
    KIND_CMD_DATA = 3'd2,
    KIND_PCM_L    = 3'd3,
    KIND_PCM_R    = 3'd4
  } slot_kind_e;
endpackage

// File: rtl/tsrx_bit_timer.sv
`timescale 1ns/1ps
module tsrx_bit_timer #(
  parameter int SLOT_W  = 20,
  parameter int TAG_W   = 16,
  parameter int N_SLOTS = 12,
  localparam int SLOT_IW = $clog2(N_SLOTS + 1),
  localparam int BIT_IW  = $clog2(SLOT_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strobe,
  output logic [SLOT_IW-1:0] slot_o,
  output logic               last_bit_o,
  output logic               take_o,
  output logic               locked_o,
  output logic               lock_err_o
);
  logic               strobe_q;
  logic [SLOT_IW-1:0] slot_q, slot_d;
  logic [BIT_IW-1:0]  bit_q, bit_d;
  logic               locked_q, locked_d;
  logic               lock_err_q;
  logic               rise, last_bit, frame_end, misalign;

  always_comb begin
    rise      = strobe & ~strobe_q;
    last_bit  = (slot_q == '0) ? (bit_q == BIT_IW'(TAG_W - 1))
                               : (bit_q == BIT_IW'(SLOT_W - 1));
    frame_end = last_bit && (slot_q == SLOT_IW'(N_SLOTS));
    misalign  = rise && locked_q && !frame_end;

    slot_d   = slot_q;
    bit_d    = bit_q;
    locked_d = locked_q;
    if (rise) begin
      slot_d   = '0;
      bit_d    = '0;
      locked_d = 1'b1;
    end else if (locked_q) begin
      if (last_bit) begin
        bit_d  = '0;
        slot_d = frame_end ? '0 : slot_q + 1'b1;
      end else begin
        bit_d  = bit_q + 1'b1;
      end
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q   <= 1'b0;
      slot_q     <= '0;
      bit_q      <= '0;
      locked_q   <= 1'b0;
      lock_err_q <= 1'b0;
    end else begin
      strobe_q   <= strobe;
      slot_q     <= slot_d;
      bit_q      <= bit_d;
      locked_q   <= locked_d;
      lock_err_q <= misalign;
    end
  end

  assign slot_o     = slot_q;
  assign last_bit_o = last_bit;
  assign take_o     = locked_q && !misalign;
  assign locked_o   = locked_q;
  assign lock_err_o = lock_err_q;

  assert_err_restarts_R10: assert property (@(negedge clk) disable iff (!rst_n)
    lock_err_q |-> (locked_q && slot_q == '0 && bit_q == '0));

  assert_idle_until_lock_R2: assert property (@(negedge clk) disable iff (!rst_n)
    !locked_q |-> (slot_q == '0 && bit_q == '0));

  assert_slot_bound_R3: assert property (@(negedge clk) disable iff (!rst_n)
    (int'(slot_q) <= N_SLOTS) && (int'(bit_q) < SLOT_W));

  assert_tag_slot_len_R3: assert property (@(negedge clk) disable iff (!rst_n)
    (slot_q == '0) |-> (int'(bit_q) < TAG_W));
endmodule

// File: rtl/tsrx_shifter.sv
`timescale 1ns/1ps
module tsrx_shifter #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         din,
  output logic [W-1:0] word_o
);
  logic [W-2:0] sr_q, sr_d;

  always_comb sr_d = {sr_q[W-3:0], din};

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  // word whose last bit is the one sampled at the current edge
  assign word_o = {sr_q, din};
endmodule

// File: rtl/tsrx_tag_capture.sv
`timescale 1ns/1ps
module tsrx_tag_capture #(
  parameter int N_SLOTS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [N_SLOTS:0] field,   // MSB = frame-valid, then tags of slot 1..N
  output logic [N_SLOTS:0] tags_o   // [0] = frame-valid, [k] = tag of slot k
);
  logic [N_SLOTS:0] rev;
  logic [N_SLOTS:0] tags_q, tags_d;

  for (genvar k = 0; k <= N_SLOTS; k++) begin : g_rev
    assign rev[k] = field[N_SLOTS - k];
  end

  always_comb tags_d = load ? rev : tags_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) tags_q <= '0;
    else        tags_q <= tags_d;
  end

  assign tags_o = tags_q;
endmodule

// File: rtl/tsrx_slot_filter.sv
`timescale 1ns/1ps
module tsrx_slot_filter
  import tsrx_pkg::*;
#(
  parameter int SLOT_IW = 4
) (
  input  logic [SLOT_IW-1:0] slot,
  input  logic               multi_en,
  input  logic [RXI_W-1:0]   rx_index,
  output logic               accept,
  output slot_kind_e         kind
);
  logic [SLOT_IW-1:0] own_first;
  logic               pcm, idx_ok;

  always_comb begin
    own_first = SLOT_IW'(PCM_FIRST) + SLOT_IW'({rx_index, 1'b0});
    pcm       = (slot >= SLOT_IW'(PCM_FIRST)) && (slot < SLOT_IW'(PCM_FIRST + 2 * N_RX));
    idx_ok    = (rx_index < RXI_W'(N_RX));
    accept    = 1'b1;
    kind      = KIND_OTHER;
    if (slot == SLOT_IW'(1)) begin
      kind = KIND_CMD_ADDR;
    end else if (slot == SLOT_IW'(2)) begin
      kind = KIND_CMD_DATA;
    end else if (pcm) begin
      if (multi_en) begin
        accept = idx_ok && ((slot == own_first) || (slot == own_first + 1'b1));
        if (accept) kind = (slot == own_first) ? KIND_PCM_L : KIND_PCM_R;
      end else if (slot == SLOT_IW'(PCM_FIRST)) begin
        kind = KIND_PCM_L;
      end else if (slot == SLOT_IW'(PCM_FIRST + 1)) begin
        kind = KIND_PCM_R;
      end
    end
  end
endmodule

// File: rtl/tslot_frame_rx.sv
`timescale 1ns/1ps
module tslot_frame_rx
  import tsrx_pkg::*;
#(
  parameter int SLOT_W  = 20,
  parameter int TAG_W   = 16,
  parameter int N_SLOTS = 12,
  localparam int SLOT_IW = $clog2(N_SLOTS + 1)
) (
  input  logic               bit_clk,
  input  logic               rst_n,
  input  logic               sync_in,
  input  logic               sdata_in,
  input  logic               multi_en,
  input  logic [RXI_W-1:0]   rx_index,
  output logic               out_valid,
  output logic [SLOT_IW-1:0] out_slot,
  output logic [SLOT_W-1:0]  out_word,
  output logic [2:0]         out_kind,
  output logic               locked,
  output logic               lock_err
);
  logic [SLOT_IW-1:0] slot;
  logic               last_bit, take;
  logic [SLOT_W-1:0]  word_now;
  logic [N_SLOTS:0]   tags;
  logic               accept, tag_load, emit;
  slot_kind_e         kind;

  logic               vld_q;
  logic [SLOT_IW-1:0] slot_q;
  logic [SLOT_W-1:0]  word_q;
  slot_kind_e         kind_q;

  tsrx_bit_timer #(.SLOT_W(SLOT_W), .TAG_W(TAG_W), .N_SLOTS(N_SLOTS)) u_timer (
    .clk(bit_clk), .rst_n(rst_n), .strobe(sync_in),
    .slot_o(slot), .last_bit_o(last_bit), .take_o(take),
    .locked_o(locked), .lock_err_o(lock_err)
  );

  tsrx_shifter #(.W(SLOT_W)) u_shift (
    .clk(bit_clk), .rst_n(rst_n), .din(sdata_in), .word_o(word_now)
  );

  tsrx_tag_capture #(.N_SLOTS(N_SLOTS)) u_tags (
    .clk(bit_clk), .rst_n(rst_n), .load(tag_load),
    .field(word_now[TAG_W-1 -: N_SLOTS+1]), .tags_o(tags)
  );

  tsrx_slot_filter #(.SLOT_IW(SLOT_IW)) u_filter (
    .slot(slot), .multi_en(multi_en), .rx_index(rx_index),
    .accept(accept), .kind(kind)
  );

  always_comb begin
    tag_load = take && last_bit && (slot == '0);
    emit     = take && last_bit && (slot != '0) && tags[0] && tags[slot] && accept;
  end

  always_ff @(negedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      slot_q <= '0;
      word_q <= '0;
      kind_q <= KIND_OTHER;
    end else begin
      vld_q <= emit;
      if (emit) begin
        slot_q <= slot;
        word_q <= word_now;
        kind_q <= kind;
      end
    end
  end

  assign out_valid = vld_q;
  assign out_slot  = slot_q;
  assign out_word  = word_q;
  assign out_kind  = kind_q;

  assert_out_needs_lock_R2: assert property (@(negedge bit_clk) disable iff (!rst_n)
    out_valid |-> locked);

  assert_single_pulse_R4: assert property (@(negedge bit_clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_tagged_only_R5: assert property (@(negedge bit_clk) disable iff (!rst_n)
    out_valid |-> (out_slot != '0 && tags[out_slot]));

  assert_frame_valid_R6: assert property (@(negedge bit_clk) disable iff (!rst_n)
    out_valid |-> tags[0]);

  assert_cmd_kind_R7: assert property (@(negedge bit_clk) disable iff (!rst_n)
    (out_valid && out_slot == SLOT_IW'(1)) |-> (out_kind == 3'(KIND_CMD_ADDR)));

  assert_pair_select_R9: assert property (@(negedge bit_clk) disable iff (!rst_n)
    (out_valid && $past(multi_en) && int'(out_slot) >= PCM_FIRST
       && int'(out_slot) < PCM_FIRST + 2 * N_RX)
    |-> (int'($past(rx_index)) < N_RX
         && (int'(out_slot) - PCM_FIRST) / 2 == int'($past(rx_index))));
endmodule

// File: tb/sim_tslot_frame_rx.sv
`timescale 1ns/1ps
module sim_tslot_frame_rx;
  localparam int CLK_PERIOD = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sync_in, sdata_in, multi_en;
  logic [1:0]  rx_index;
  logic        out_valid, locked, lock_err;
  logic [3:0]  out_slot;
  logic [19:0] out_word;
  logic [2:0]  out_kind;

  typedef struct {
    int          slot;
    logic [19:0] word;
    int          kind;
  } exp_t;

  exp_t  exp_q[$];
  int    n_chk = 0, n_fail = 0, err_seen = 0;
  string cur_req = "R12";
  bit    done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tslot_frame_rx u0 (
    .bit_clk(clk), .rst_n(rst_n), .sync_in(sync_in), .sdata_in(sdata_in),
    .multi_en(multi_en), .rx_index(rx_index), .out_valid(out_valid),
    .out_slot(out_slot), .out_word(out_word), .out_kind(out_kind),
    .locked(locked), .lock_err(lock_err)
  );

  task automatic chk(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // scoreboard monitor: outputs change on falling edges, sampled on rising edges
  always @(posedge clk) begin
    if (rst_n === 1'b1 && lock_err === 1'b1) err_seen++;
    if (rst_n === 1'b1 && out_valid === 1'b1) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL %s unexpected output slot actual=%0d expected=none", cur_req, out_slot);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (int'(out_slot) != e.slot || out_word !== e.word || int'(out_kind) != e.kind) begin
          n_fail++;
          $display("FAIL %s R4 slot/word/kind actual=%0d/%h/%0d expected=%0d/%h/%0d",
                   cur_req, out_slot, out_word, out_kind, e.slot, e.word, e.kind);
        end
      end
    end
  end

  function automatic logic [19:0] mk_word(int f, int k);
    return 20'((f * 9973 + k * 4099 + 32'h35A1C) ^ (k << 15));
  endfunction

  // R7 R8 R9 kind and acceptance rules
  function automatic bit exp_accept(int k, bit m, int idx);
    if (m && k >= 3 && k <= 8) return (idx < 3) && (k == 3 + 2*idx || k == 4 + 2*idx);
    return 1'b1;
  endfunction

  function automatic int exp_kind(int k, bit m, int idx);
    if (k == 1) return 1;
    if (k == 2) return 2;
    if (k >= 3 && k <= 8) begin
      if (!m) return (k == 3) ? 3 : (k == 4) ? 4 : 0;
      if (k == 3 + 2*idx) return 3;
      if (k == 4 + 2*idx) return 4;
    end
    return 0;
  endfunction

  // R3 layout: bit 0 valid, bits 1..12 tags, slot k at 16+20(k-1), MSB first
  task automatic send_frame(int f, bit fv, logic [12:1] tags, bit m, int idx,
                            bit own_sync, bit next_sync, int nbits);
    bit fb[256];
    for (int i = 0; i < 256; i++) fb[i] = 1'b0;
    fb[0] = fv;
    for (int k = 1; k <= 12; k++) begin
      logic [19:0] w;
      fb[k] = tags[k];
      w = mk_word(f, k);
      for (int j = 0; j < 20; j++) fb[16 + 20*(k-1) + j] = w[19-j];
      if (fv && tags[k] && exp_accept(k, m, idx) && (16 + 20*k - 1) < nbits) begin
        exp_t e;
        e.slot = k; e.word = w; e.kind = exp_kind(k, m, idx);
        exp_q.push_back(e);
      end
    end
    for (int i = 0; i < nbits; i++) begin
      @(posedge clk);
      if (i == 0) begin
        multi_en <= m;
        rx_index <= 2'(idx);
      end
      sdata_in <= fb[i];
      sync_in  <= (own_sync && i < 15) || (i == 255 && next_sync);
    end
  endtask

  task automatic raise_sync();
    @(posedge clk);
    sync_in  <= 1'b1;
    sdata_in <= 1'b0;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R4 watchdog actual=timeout expected=completion");
      report();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sync_in = 1'b0; sdata_in = 1'b0; multi_en = 1'b0; rx_index = 2'd0;
    repeat (5) @(posedge clk);
    chk(out_valid == 1'b0 && locked == 1'b0 && lock_err == 1'b0, "R12",
        "outputs in reset", {out_valid, locked, lock_err}, 0);
    rst_n <= 1'b1;

    // R2: data toggling without any strobe edge
    cur_req = "R2";
    for (int i = 0; i < 300; i++) begin
      @(posedge clk);
      sdata_in <= 1'(i ^ (i >> 2));
    end
    @(posedge clk);
    chk(locked == 1'b0, "R2", "locked before first strobe", locked, 0);

    // R1 R3 R4 R7 R8: first frame, all tags
    cur_req = "R1 R3 R4 R7 R8";
    raise_sync();
    send_frame(1, 1'b1, 12'hFFF, 1'b0, 0, 1'b1, 1'b1, 256);
    chk(locked == 1'b1, "R1", "locked after frame start", locked, 1);

    cur_req = "R5";
    send_frame(2, 1'b1, 12'b1010_0110_1001, 1'b0, 0, 1'b1, 1'b1, 256);
    cur_req = "R6";
    send_frame(3, 1'b0, 12'hFFF, 1'b0, 0, 1'b1, 1'b1, 256);

    cur_req = "R9";
    for (int idx = 0; idx < 4; idx++)
      send_frame(4 + idx, 1'b1, 12'hFFF, 1'b1, idx, 1'b1, 1'b1, 256);

    // R11: a frame without its own strobe is decoded after the wrap
    cur_req = "R11";
    send_frame(8, 1'b1, 12'hFFF, 1'b0, 0, 1'b1, 1'b0, 256);
    send_frame(9, 1'b1, 12'h5A5, 1'b0, 0, 1'b0, 1'b1, 256);
    send_frame(10, 1'b1, 12'hFFF, 1'b0, 0, 1'b1, 1'b1, 256);
    chk(err_seen == 0, "R10", "lock_err pulses on aligned edges", err_seen, 0);

    // R10: truncated frame, then an early strobe edge
    cur_req = "R10";
    send_frame(11, 1'b1, 12'hFFF, 1'b0, 0, 1'b1, 1'b0, 100);
    raise_sync();
    send_frame(12, 1'b1, 12'hFFF, 1'b0, 0, 1'b1, 1'b1, 256);
    send_frame(13, 1'b1, 12'hC3F, 1'b0, 0, 1'b1, 1'b0, 256);
    @(posedge clk);
    sdata_in <= 1'b0;
    sync_in  <= 1'b0;
    repeat (40) @(posedge clk);
    chk(err_seen == 1, "R10", "lock_err pulses after misaligned edge", err_seen, 1);
    chk(exp_q.size() == 0, "R4", "expected words left undelivered", exp_q.size(), 0);

    // R12: asynchronous reset between clock edges
    #(CLK_PERIOD/4);
    rst_n = 1'b0;
    #1;
    chk(locked == 1'b0 && out_valid == 1'b0 && lock_err == 1'b0, "R12",
        "outputs right after async reset", {out_valid, locked, lock_err}, 0);

    done = 1'b1;
    report();
    $finish;
  end
endmodule